// File: doc/BRIEF.md
# Indexed Block Register Target on a Two-Wire Serial Bus

This block is an I2C target that holds a bank of 8-bit configuration registers and drives their contents straight to internal logic. The host moves data with indexed block transfers. A write names a starting register and a byte count, then supplies that many data bytes. A read first sets the index with a short write, then issues a repeated start with the read address. The target answers with the byte count, followed by register contents from the chosen index onward.

SCL and SDA reach the block through a two-flop synchroniser and a glitch filter that run on the system clock. Start and stop conditions are decoded from SDA edges while SCL is high. Either condition abandons whatever transfer is in progress. The target drives SDA only through an open-drain pull-down enable. The register index advances by itself after each data byte. Bytes aimed past the last implemented register are acknowledged but discarded.

Top module: `i2cbr_slave`

## Requirements
- R1: After reset the SDA pull-down is released, register i holds 0xA0+i, and the count register holds the parameter CNT_RST.
- R2: Only the address bytes 0xD2 (write) and 0xD3 (read), that is 7-bit address 0x69 with R/W in bit 0, are acknowledged. Any other address is not acknowledged, and every later byte up to the next start or stop is also left unacknowledged.
- R3: A write carries address, index N, count X, then data bytes. The data bytes are stored in registers N, N+1, … in order, and the index advances after each accepted byte.
- R4: The target acknowledges the address, the index, the count and each accepted data byte by pulling SDA low for the whole ninth clock of that byte.
- R5: The count byte of a write is stored in the count register. Data bytes beyond the first X are not acknowledged and not stored.
- R6: A data byte aimed at an index of NUM_REGS or above is acknowledged, changes no register, and still advances the index.
- R7: After a repeated start with 0xD3, the first byte sent is the count register. It is followed by registers N, N+1, … for as long as the host acknowledges.
- R8: A read of an index of NUM_REGS or above returns 0x00.
- R9: When the host does not acknowledge a read byte, the target releases SDA and drives nothing until the next start.
- R10: A start or stop at any bit position aborts the transfer and drops any partial byte. A start then expects an address byte.
- R11: Pulses on SCL or SDA shorter than FILT_LEN system clocks have no effect.
- R12: The SDA pull-down changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When high, pull SDA low |
| regs_o | output | NUM_REGS*8 | Register contents; register i occupies bits 8i+7..8i |

## Verification
The bench builds the block with NUM_REGS = 6 and FILT_LEN = 3. At that size, every starting index, together with every count from one up to one more than the registers left, can be written and read back within the cycle budget. Those sweeps cross the last register on both writes and reads, and always push one data byte past the declared count. A filter length of 3 lets two-clock glitches on both lines be injected in the middle of a transfer. Separate cases cover a foreign address, a read issued before any write, an abort by start and by stop in the middle of a byte, and a clock after the host's final not-acknowledge.

// File: rtl/i2cbr_pkg.sv
package i2cbr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } st_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_IDX,
        PH_CNT,
        PH_DATA
    } ph_e;

    typedef struct packed {
        logic       we;
        logic [7:0] idx;
        logic [7:0] data;
    } wr_s;

    function automatic ph_e ph_next(ph_e p);
        case (p)
            PH_ADDR: return PH_IDX;
            PH_IDX:  return PH_CNT;
            default: return PH_DATA;
        endcase
    endfunction

    function automatic logic [7:0] reg_rst_val(int i);
        return 8'(8'hA0 + i);
    endfunction

endpackage

// File: rtl/i2cbr_filt.sv
module i2cbr_filt #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            out_q  <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], din};
            if (sync_q[1] == out_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_LEN - 1)) begin
                out_q <= sync_q[1];
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign dout = out_q;
endmodule

// File: rtl/i2cbr_cond.sv
module i2cbr_cond (
    input  logic clk,
    input  logic rst,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    assign scl_rise  = scl_f & ~scl_p;
    assign scl_fall  = ~scl_f & scl_p;
    assign start_det = scl_f & scl_p & sda_p & ~sda_f;
    assign stop_det  = scl_f & scl_p & ~sda_p & sda_f;
endmodule

// File: rtl/i2cbr_regbank.sv
module i2cbr_regbank import i2cbr_pkg::*; #(
    parameter int NUM_REGS = 20
) (
    input  logic                  clk,
    input  logic                  rst,
    input  wr_s                   wr,
    input  logic [7:0]            ridx,
    output logic [7:0]            rdata,
    output logic [NUM_REGS*8-1:0] regs_o
);
    logic [7:0] mem [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= reg_rst_val(g);
            else if (wr.we && wr.idx == 8'(g))
                mem[g] <= wr.data;
        end
        assign regs_o[g*8 +: 8] = mem[g];
    end

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < NUM_REGS; i++)
            if (ridx == 8'(i)) rdata = mem[i];
    end
endmodule

// File: rtl/i2cbr_slave.sv
module i2cbr_slave import i2cbr_pkg::*; #(
    parameter int         NUM_REGS = 20,
    parameter int         FILT_LEN = 3,
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter logic [7:0] CNT_RST  = 8'h07
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] regs_o
);
    logic scl_f, sda_f;
    logic scl_rise, scl_fall, start_det, stop_det;

    i2cbr_filt #(.FILT_LEN(FILT_LEN)) u_scl_filt (
        .clk(clk), .rst(rst), .din(scl_i), .dout(scl_f)
    );
    i2cbr_filt #(.FILT_LEN(FILT_LEN)) u_sda_filt (
        .clk(clk), .rst(rst), .din(sda_i), .dout(sda_f)
    );
    i2cbr_cond u_cond (
        .clk(clk), .rst(rst), .scl_f(scl_f), .sda_f(sda_f),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    st_e        state_q;
    ph_e        phase_q;
    logic [3:0] bitcnt_q;
    logic [7:0] shreg_q, txreg_q, idx_q, cnt_q, wrem_q;
    logic       is_read_q, mack_q, sda_oe_q;

    wr_s        wr;
    logic [7:0] rdata;
    logic       bank_we;
    logic [7:0] bank_idx;
    logic       byte_done;

    assign byte_done = (state_q == ST_RX) && scl_fall && (bitcnt_q == 4'd8);

    always_comb begin
        wr      = '0;
        wr.idx  = idx_q;
        wr.data = shreg_q;
        wr.we   = byte_done && (phase_q == PH_DATA) && (wrem_q != 8'd0);
    end
    assign bank_we  = wr.we;
    assign bank_idx = wr.idx;

    i2cbr_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk(clk), .rst(rst), .wr(wr), .ridx(idx_q),
        .rdata(rdata), .regs_o(regs_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            phase_q   <= PH_ADDR;
            bitcnt_q  <= '0;
            shreg_q   <= '0;
            txreg_q   <= '0;
            idx_q     <= '0;
            cnt_q     <= CNT_RST;
            wrem_q    <= '0;
            is_read_q <= 1'b0;
            mack_q    <= 1'b0;
            sda_oe_q  <= 1'b0;
        end else if (start_det) begin
            state_q  <= ST_RX;
            phase_q  <= PH_ADDR;
            bitcnt_q <= '0;
            sda_oe_q <= 1'b0;
        end else if (stop_det) begin
            state_q  <= ST_IDLE;
            sda_oe_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_RX: begin
                    if (scl_rise && bitcnt_q != 4'd8) begin
                        shreg_q  <= {shreg_q[6:0], sda_f};
                        bitcnt_q <= bitcnt_q + 1'b1;
                    end
                    if (byte_done) begin
                        unique case (phase_q)
                            PH_ADDR: begin
                                if (shreg_q[7:1] == DEV_ADDR) begin
                                    is_read_q <= shreg_q[0];
                                    state_q   <= ST_ACK;
                                    sda_oe_q  <= 1'b1;
                                end else begin
                                    state_q <= ST_IDLE;
                                end
                            end
                            PH_IDX: begin
                                idx_q    <= shreg_q;
                                state_q  <= ST_ACK;
                                sda_oe_q <= 1'b1;
                            end
                            PH_CNT: begin
                                cnt_q    <= shreg_q;
                                wrem_q   <= shreg_q;
                                state_q  <= ST_ACK;
                                sda_oe_q <= 1'b1;
                            end
                            PH_DATA: begin
                                if (wrem_q != 8'd0) begin
                                    idx_q    <= idx_q + 1'b1;
                                    wrem_q   <= wrem_q - 1'b1;
                                    state_q  <= ST_ACK;
                                    sda_oe_q <= 1'b1;
                                end else begin
                                    state_q <= ST_IDLE;
                                end
                            end
                            default: state_q <= ST_IDLE;
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        bitcnt_q <= '0;
                        if (phase_q == PH_ADDR && is_read_q) begin
                            state_q  <= ST_TX;
                            txreg_q  <= cnt_q;
                            sda_oe_q <= ~cnt_q[7];
                        end else begin
                            state_q  <= ST_RX;
                            phase_q  <= ph_next(phase_q);
                            sda_oe_q <= 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) bitcnt_q <= bitcnt_q + 1'b1;
                    if (scl_fall) begin
                        if (bitcnt_q == 4'd8) begin
                            state_q  <= ST_MACK;
                            sda_oe_q <= 1'b0;
                        end else begin
                            txreg_q  <= {txreg_q[6:0], 1'b0};
                            sda_oe_q <= ~txreg_q[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) mack_q <= ~sda_f;
                    if (scl_fall) begin
                        bitcnt_q <= '0;
                        if (mack_q) begin
                            state_q  <= ST_TX;
                            txreg_q  <= rdata;
                            sda_oe_q <= ~rdata[7];
                            idx_q    <= idx_q + 1'b1;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign sda_oe = sda_oe_q;
endmodule

// File: rtl/i2cbr_chk.sv
module i2cbr_chk import i2cbr_pkg::*; #(
    parameter int NUM_REGS = 20
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  scl_f,
    input logic                  start_det,
    input logic                  stop_det,
    input st_e                   state,
    input ph_e                   phase,
    input logic [3:0]            bitcnt,
    input logic                  sda_oe,
    input logic [NUM_REGS*8-1:0] regs,
    input logic                  bank_we,
    input logic [7:0]            bank_idx
);
    AST_RST_RELEASE: assert property (@(posedge clk) rst |=> !sda_oe); // R1

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_f); // R12

    AST_ACK_NINTH: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACK && $rose(sda_oe)) |-> $past(bitcnt) == 4'd8); // R4

    AST_START_ABORT: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (state == ST_RX && phase == PH_ADDR && bitcnt == 4'd0)); // R10

    AST_STOP_ABORT: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (state == ST_IDLE && !sda_oe)); // R10

    AST_REG_SRC: assert property (@(posedge clk) disable iff (rst)
        !$stable(regs) |-> $past(bank_we)); // R3

    AST_REG_RANGE: assert property (@(posedge clk) disable iff (rst)
        !$stable(regs) |-> $past(bank_idx) < 8'(NUM_REGS)); // R6
endmodule

bind i2cbr_slave i2cbr_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk(clk), .rst(rst), .scl_f(scl_f),
    .start_det(start_det), .stop_det(stop_det),
    .state(state_q), .phase(phase_q), .bitcnt(bitcnt_q),
    .sda_oe(sda_oe), .regs(regs_o),
    .bank_we(bank_we), .bank_idx(bank_idx)
);

// File: tb/i2cbr_slave_tb.sv
module i2cbr_slave_tb;
    localparam int         NUM  = 6;
    localparam int         FILT = 3;
    localparam logic [6:0] ADDR = 7'h69;
    localparam logic [7:0] CRST = 8'h07;
    localparam int         PH   = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic sda_oe;
    logic [NUM*8-1:0] regs_o;
    wire  sda_line = sda_h & ~sda_oe;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [7:0] mdl [NUM];
    logic [7:0] mdl_cnt;

    always #10 clk = ~clk;

    i2cbr_slave #(.NUM_REGS(NUM), .FILT_LEN(FILT), .DEV_ADDR(ADDR), .CNT_RST(CRST)) u_dut (
        .clk(clk), .rst(rst), .scl_i(scl_h), .sda_i(sda_line),
        .sda_oe(sda_oe), .regs_o(regs_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b, input bit g);
        scl_h = 1'b0; wt(PH);
        sda_h = b;    wt(PH);
        scl_h = 1'b1;
        if (g) begin
            wt(3); scl_h = 1'b0; wt(2); scl_h = 1'b1;
            wt(2); sda_h = ~b;   wt(2); sda_h = b; wt(3);
        end else begin
            wt(2*PH);
        end
    endtask

    task automatic bit_in(output logic b);
        scl_h = 1'b0; wt(PH);
        sda_h = 1'b1; wt(PH);
        scl_h = 1'b1; wt(PH);
        b = sda_line; wt(PH);
    endtask

    task automatic i2c_start();
        scl_h = 1'b0; wt(PH);
        sda_h = 1'b1; wt(PH);
        scl_h = 1'b1; wt(PH);
        sda_h = 1'b0; wt(PH);
    endtask

    task automatic i2c_stop();
        scl_h = 1'b0; wt(PH);
        sda_h = 1'b0; wt(PH);
        scl_h = 1'b1; wt(PH);
        sda_h = 1'b1; wt(2*PH);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit g, output bit ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(b[i], g);
        bit_in(a);
        ack = !a;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            bit_in(v);
            b[i] = v;
        end
        bit_out(!give_ack, 1'b0);
    endtask

    task automatic chk_regs(input string req);
        for (int i = 0; i < NUM; i++)
            chk(regs_o[i*8 +: 8] === mdl[i], req, int'(regs_o[i*8 +: 8]), int'(mdl[i]));
    endtask

    function automatic logic [7:0] dval(input int n, input int x, input int k);
        return 8'(n*29 + x*13 + k*7 + 3);
    endfunction

    task automatic write_txn(input int n, input int x, input int nb, input bit g);
        bit ack;
        int p;
        logic [7:0] d;
        i2c_start();
        send_byte({ADDR, 1'b0}, g, ack); chk(ack, "R4 addr ack", int'(ack), 1);
        send_byte(8'(n), g, ack);        chk(ack, "R4 index ack", int'(ack), 1);
        send_byte(8'(x), g, ack);        chk(ack, "R4 count ack", int'(ack), 1);
        mdl_cnt = 8'(x);
        p = n;
        for (int k = 0; k < nb; k++) begin
            d = dval(n, x, k);
            send_byte(d, g, ack);
            if (k < x) begin
                chk(ack, (p < NUM) ? "R4 data ack" : "R6 ack past end", int'(ack), 1);
                if (p < NUM) mdl[p] = d;
                p++;
            end else begin
                chk(!ack, "R5 byte beyond count", int'(ack), 0);
                break;
            end
        end
        i2c_stop();
        chk_regs((n + x > NUM) ? "R6 regs" : "R3 regs");
    endtask

    task automatic read_txn(input int n, input int nb, input bit extra);
        bit ack;
        logic [7:0] b;
        logic [7:0] e;
        i2c_start();
        send_byte({ADDR, 1'b0}, 1'b0, ack); chk(ack, "R4 addr ack", int'(ack), 1);
        send_byte(8'(n), 1'b0, ack);        chk(ack, "R4 index ack", int'(ack), 1);
        i2c_start();
        send_byte({ADDR, 1'b1}, 1'b0, ack); chk(ack, "R2 read addr ack", int'(ack), 1);
        recv_byte(nb > 0, b);
        chk(b === mdl_cnt, "R7 count byte", int'(b), int'(mdl_cnt));
        for (int k = 0; k < nb; k++) begin
            recv_byte(k < nb - 1, b);
            e = (n + k < NUM) ? mdl[n + k] : 8'h00;
            chk(b === e, (n + k < NUM) ? "R7 read data" : "R8 read past end", int'(b), int'(e));
        end
        if (extra) begin
            recv_byte(1'b0, b);
            chk(b === 8'hFF, "R9 released after nack", int'(b), 255);
        end
        i2c_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        bit ack;
        for (int i = 0; i < NUM; i++) mdl[i] = 8'(8'hA0 + i);
        mdl_cnt = CRST;
        wt(5);
        rst = 1'b0;
        wt(5);

        // R1: reset state
        chk(sda_oe == 1'b0, "R1 sda released", int'(sda_oe), 0);
        chk_regs("R1 reset values");
        read_txn(0, 2, 1'b1);   // R1 count reset value, R9 release

        // R2: foreign address, following bytes ignored
        i2c_start();
        send_byte({7'h3A, 1'b0}, 1'b0, ack); chk(!ack, "R2 foreign addr nack", int'(ack), 0);
        send_byte(8'h01, 1'b0, ack);         chk(!ack, "R2 later byte nack", int'(ack), 0);
        send_byte(8'h01, 1'b0, ack);         chk(!ack, "R2 later byte nack", int'(ack), 0);
        send_byte(8'h55, 1'b0, ack);         chk(!ack, "R2 later byte nack", int'(ack), 0);
        i2c_stop();
        chk_regs("R2 regs untouched");

        // R3 R5 R6 R7 R8: sweep every start index and count
        for (int n = 0; n < NUM; n++) begin
            for (int x = 1; x <= NUM - n + 1; x++) begin
                write_txn(n, x, x + 1, 1'b0);
            end
            read_txn(n, NUM - n + 1, 1'b0);
        end

        // R5: zero count rejects first data byte
        write_txn(2, 0, 1, 1'b0);

        // R10: repeated start in the middle of a data byte
        i2c_start();
        send_byte({ADDR, 1'b0}, 1'b0, ack); chk(ack, "R10 addr ack", int'(ack), 1);
        send_byte(8'd2, 1'b0, ack);
        send_byte(8'd3, 1'b0, ack);
        send_byte(8'h5A, 1'b0, ack);        chk(ack, "R10 first data ack", int'(ack), 1);
        mdl[2] = 8'h5A;
        for (int i = 0; i < 4; i++) bit_out(1'b0, 1'b0);
        i2c_start();
        send_byte({ADDR, 1'b0}, 1'b0, ack); chk(ack, "R10 addr after restart", int'(ack), 1);
        send_byte(8'd4, 1'b0, ack);
        send_byte(8'd1, 1'b0, ack);
        send_byte(8'h6B, 1'b0, ack);        chk(ack, "R10 data after restart", int'(ack), 1);
        mdl[4] = 8'h6B;
        mdl_cnt = 8'd1;
        i2c_stop();
        chk_regs("R10 partial byte dropped");

        // R10: stop in the middle of a data byte
        i2c_start();
        send_byte({ADDR, 1'b0}, 1'b0, ack);
        send_byte(8'd0, 1'b0, ack);
        send_byte(8'd2, 1'b0, ack);
        mdl_cnt = 8'd2;
        for (int i = 0; i < 3; i++) bit_out(1'b1, 1'b0);
        i2c_stop();
        chk(sda_oe == 1'b0, "R10 released after stop", int'(sda_oe), 0);
        chk_regs("R10 stop drops byte");
        read_txn(0, 1, 1'b0);

        // R11: short glitches on both lines during a write
        write_txn(1, 3, 3, 1'b1);
        read_txn(1, 3, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule